// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer

A watchdog peripheral clocked from a 32.768 kHz always-on clock. Software programs a timeout in half-second units and turns the watchdog on. From then on software must refresh the counter at intervals by writing an ordered pair of key words to the service register. If it stops doing so, the counter reaches zero, and the block issues a one-cycle internal (system) reset pulse and an optional external reset pulse. Each pulse can be masked separately.

An optional early-warning interrupt fires a programmable number of units before expiry. Counting pauses while the chip is in wait, debug or low-power mode, but only for the modes whose suspend bit is set. A cause register reports whether the most recent reset came from power-on, a watchdog expiry or a software reset request. After an expiry or a software reset the configuration returns to its reset values.

The register interface is a 16-bit write port with a combinational read port. The registers sit at byte offsets 0x0 (control), 0x2 (service), 0x4 (reset cause), 0x6 (interrupt control) and 0x8 (miscellaneous).

Top module: `lf_watchdog`

## Requirements
- R1: After power-on reset, control reads 0x0000, interrupt control reads 0x0000, reset cause reads 0x0010 (bit 4 = power-on), and all three outputs are low.
- R2: Writing control with bit 2 (enable) set and bits 15:8 = T starts the count. int_rst_o rises exactly (T+1)*UNIT_CYCLES clock edges after the write edge, and it stays high for exactly one cycle.
- R3: On expiry, int_rst_o pulses unless control bit 4 is set. ext_rst_o pulses only if control bit 3 is set and control bit 5 is clear.
- R4: Writing 0x5555 and then 0xAAAA to the service register (0x2) reloads the counter to T+1 units, with the prescaler cleared, at the edge of the second write.
- R5: Any other value written to the service register after 0x5555, and any write to another register between the two keys, cancels the sequence, so a following 0xAAAA does not reload.
- R6: Once the enable bit is 1, a write of 0 to it is ignored until an expiry, a software reset or a power-on reset.
- R7: Counting holds while wait_mode_i and control bit 7 are both high, while dbg_mode_i and control bit 1 are both high, or while lp_mode_i and control bit 0 are both high. A mode input whose suspend bit is clear has no effect.
- R8: With interrupt-control bits 7:0 = L (L > 0), flag bit 14 sets on the unit tick that leaves L units remaining. irq_o is the flag ANDed with bit 15. Writing 1 to bit 14 clears the flag.
- R9: After an expiry, reset cause reads 0x0002 (bit 1) and control and interrupt control read 0x0000.
- R10: A one-cycle pulse on sw_rst_i stops the watchdog, clears the configuration and makes reset cause read 0x0001 (bit 0).
- R11: Bit 0 of the miscellaneous register (0x8) is read/write storage and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-frequency clock (32.768 kHz) |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sw_rst_i | input | 1 | Software reset request, one cycle |
| wait_mode_i | input | 1 | Chip in wait mode |
| dbg_mode_i | input | 1 | Chip halted in debug |
| lp_mode_i | input | 1 | Chip in low-power mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| int_rst_o | output | 1 | Internal reset pulse on expiry |
| ext_rst_o | output | 1 | External reset pulse on expiry |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The bench builds the block with UNIT_CYCLES = 4 instead of 16384. A half-second unit then lasts four cycles, and a full timeout, a pre-timeout lead and a suspended interval each span only a few tens of cycles. This makes the exact expiry edge, the interrupt edge and the shift caused by suspension checkable to the cycle. Broken key sequences, reset masks and cause recording can each be exercised in many separate rounds within a short run.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;
  localparam int TMO_W  = 8;

  localparam logic [REG_AW-1:0] A_CTRL  = 4'h0;
  localparam logic [REG_AW-1:0] A_SVC   = 4'h2;
  localparam logic [REG_AW-1:0] A_CAUSE = 4'h4;
  localparam logic [REG_AW-1:0] A_IRQC  = 4'h6;
  localparam logic [REG_AW-1:0] A_MISC  = 4'h8;

  localparam logic [REG_DW-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_DW-1:0] KEY_FIRE = 16'hAAAA;

  // layout matches the control register bit positions
  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             susp_wait;
    logic             rsvd6;
    logic             no_ext;
    logic             no_int;
    logic             ext_en;
    logic             run_en;
    logic             susp_dbg;
    logic             susp_lp;
  } ctrl_t;

  typedef struct packed {
    logic             irq_en;
    logic             irq_flag;
    logic [5:0]       rsvd;
    logic [TMO_W-1:0] lead;
  } irqc_t;

  typedef struct packed {
    logic por;
    logic tmo;
    logic sft;
  } cause_t;

  function automatic logic [REG_DW-1:0] cause_word(cause_t c);
    return {11'b0, c.por, 2'b00, c.tmo, c.sft};
  endfunction
endpackage

// File: rtl/lfw_regs.sv
module lfw_regs
  import lfw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              tmo_evt_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              flag_set_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              start_o,
  output logic [TMO_W-1:0]  load_tmo_o,
  output logic              svc_we_o,
  output logic              other_we_o,
  output logic              run_en_o,
  output logic [2:0]        susp_en_o,
  output logic              ext_en_o,
  output logic              no_ext_o,
  output logic              no_int_o,
  output logic              irq_en_o,
  output logic              irq_flag_o,
  output logic [TMO_W-1:0]  lead_o,
  output cause_t            cause_o
);
  ctrl_t  ctrl_q, ctrl_n;
  irqc_t  irqc_q, irqc_n;
  cause_t cause_q;
  logic   misc_q;
  logic   ctrl_we, irqc_we, misc_we;

  assign ctrl_we    = we_i && (addr_i == A_CTRL);
  assign irqc_we    = we_i && (addr_i == A_IRQC);
  assign misc_we    = we_i && (addr_i == A_MISC);
  assign svc_we_o   = we_i && (addr_i == A_SVC);
  assign other_we_o = we_i && (addr_i != A_SVC);

  always_comb begin
    ctrl_n        = ctrl_t'(wdata_i);
    ctrl_n.rsvd6  = 1'b0;
    ctrl_n.run_en = wdata_i[2] | ctrl_q.run_en;  // enable is sticky
    irqc_n          = irqc_t'(wdata_i);
    irqc_n.rsvd     = '0;
    irqc_n.irq_flag = flag_set_i | (irqc_q.irq_flag & ~wdata_i[14]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      irqc_q  <= '0;
      misc_q  <= 1'b0;
      cause_q <= '{por: 1'b1, tmo: 1'b0, sft: 1'b0};
    end else if (tmo_evt_i || sw_rst_i) begin
      ctrl_q  <= '0;
      irqc_q  <= '0;
      misc_q  <= 1'b0;
      cause_q <= tmo_evt_i ? '{por: 1'b0, tmo: 1'b1, sft: 1'b0}
                           : '{por: 1'b0, tmo: 1'b0, sft: 1'b1};
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_n;
      if (irqc_we) irqc_q <= irqc_n;
      else if (flag_set_i) irqc_q.irq_flag <= 1'b1;
      if (misc_we) misc_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_CAUSE: rdata_o = cause_word(cause_q);
      A_IRQC:  rdata_o = irqc_q;
      A_MISC:  rdata_o = {{(REG_DW-1){1'b0}}, misc_q};
      default: rdata_o = '0;
    endcase
  end

  assign start_o    = ctrl_we && wdata_i[2] && !ctrl_q.run_en;
  assign load_tmo_o = ctrl_we ? wdata_i[15:8] : ctrl_q.tmo;
  assign run_en_o   = ctrl_q.run_en;
  assign susp_en_o  = {ctrl_q.susp_wait, ctrl_q.susp_dbg, ctrl_q.susp_lp};
  assign ext_en_o   = ctrl_q.ext_en;
  assign no_ext_o   = ctrl_q.no_ext;
  assign no_int_o   = ctrl_q.no_int;
  assign irq_en_o   = irqc_q.irq_en;
  assign irq_flag_o = irqc_q.irq_flag;
  assign lead_o     = irqc_q.lead;
  assign cause_o    = cause_q;
endmodule

// File: rtl/lfw_keyseq.sv
module lfw_keyseq
  import lfw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              svc_we_i,
  input  logic              other_we_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic              reload_o
);
  typedef enum logic {KS_IDLE, KS_ARMED} ks_e;
  ks_e state_q;

  assign reload_o = svc_we_i && (state_q == KS_ARMED) && (wdata_i == KEY_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
    end else if (clr_i || other_we_i) begin
      state_q <= KS_IDLE;
    end else if (svc_we_i) begin
      // any service write other than the arm key drops back to idle
      state_q <= (wdata_i == KEY_ARM) ? KS_ARMED : KS_IDLE;
    end
  end
endmodule

// File: rtl/lfw_counter.sv
module lfw_counter #(
  parameter int UNIT_CYCLES = 16384,
  parameter int TMO_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] load_tmo_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] lead_i,
  output logic [TMO_W:0]   units_o,
  output logic             tmo_evt_o,
  output logic             flag_set_o
);
  localparam int UNITS_W = TMO_W + 1;
  localparam int PRE_W   = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [UNITS_W-1:0] units_q;
  logic               tick;

  assign tick       = run_i && (pre_q == PRE_LAST);
  assign tmo_evt_o  = tick && (units_q == UNITS_W'(1));
  assign flag_set_o = tick && (lead_i != '0) &&
                      ((units_q - UNITS_W'(1)) == {1'b0, lead_i});
  assign units_o    = units_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (clr_i) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (start_i || reload_i) begin
      pre_q   <= '0;
      units_q <= {1'b0, load_tmo_i} + UNITS_W'(1);
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) units_q <= units_q - UNITS_W'(1);
    end
  end
endmodule

// File: rtl/lf_watchdog.sv
module lf_watchdog
  import lfw_pkg::*;
#(
  parameter int UNIT_CYCLES = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              wait_mode_i,
  input  logic              dbg_mode_i,
  input  logic              lp_mode_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              int_rst_o,
  output logic              ext_rst_o,
  output logic              irq_o
);
  logic             start, svc_we, other_we, reload;
  logic [TMO_W-1:0] load_tmo, lead;
  logic             run_en, ext_en, no_ext, no_int, irq_en, irq_flag;
  logic [2:0]       susp_en;
  logic             susp, tmo_evt, flag_set;
  logic [TMO_W:0]   units;
  cause_t           cause;
  logic             int_rst_q, ext_rst_q;

  lfw_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_rst_i   (sw_rst_i),
    .tmo_evt_i  (tmo_evt),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flag_set_i (flag_set),
    .rdata_o    (reg_rdata_o),
    .start_o    (start),
    .load_tmo_o (load_tmo),
    .svc_we_o   (svc_we),
    .other_we_o (other_we),
    .run_en_o   (run_en),
    .susp_en_o  (susp_en),
    .ext_en_o   (ext_en),
    .no_ext_o   (no_ext),
    .no_int_o   (no_int),
    .irq_en_o   (irq_en),
    .irq_flag_o (irq_flag),
    .lead_o     (lead),
    .cause_o    (cause)
  );

  lfw_keyseq u_keyseq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sw_rst_i | tmo_evt),
    .svc_we_i   (svc_we),
    .other_we_i (other_we),
    .wdata_i    (reg_wdata_i),
    .reload_o   (reload)
  );

  // susp_en = {wait, debug, low-power}
  assign susp = |(susp_en & {wait_mode_i, dbg_mode_i, lp_mode_i});

  lfw_counter #(
    .UNIT_CYCLES (UNIT_CYCLES),
    .TMO_W       (TMO_W)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sw_rst_i | tmo_evt),
    .start_i    (start),
    .reload_i   (reload),
    .load_tmo_i (load_tmo),
    .run_i      (run_en & ~susp),
    .lead_i     (lead),
    .units_o    (units),
    .tmo_evt_o  (tmo_evt),
    .flag_set_o (flag_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_rst_q <= 1'b0;
      ext_rst_q <= 1'b0;
    end else begin
      int_rst_q <= tmo_evt & ~no_int;
      ext_rst_q <= tmo_evt & ext_en & ~no_ext;
    end
  end

  assign int_rst_o = int_rst_q;
  assign ext_rst_o = ext_rst_q;
  assign irq_o     = irq_en & irq_flag;
endmodule

// File: rtl/lf_watchdog_chk.sv
module lf_watchdog_chk
  import lfw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_rst_i,
  input logic             int_rst_o,
  input logic             ext_rst_o,
  input logic             run_en,
  input logic             ext_en,
  input logic             no_ext,
  input logic             no_int,
  input logic             tmo_evt,
  input logic             susp,
  input logic             reload,
  input logic [TMO_W-1:0] load_tmo,
  input logic [TMO_W:0]   units,
  input logic [TMO_W-1:0] lead,
  input logic             irq_flag,
  input cause_t           cause
);
  p_rst_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |=> !int_rst_o);

  p_ext_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_o |-> $past(ext_en && !no_ext));

  p_int_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> $past(!no_int));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !tmo_evt && !sw_rst_i) |=> (units == ({1'b0, $past(load_tmo)} + 9'd1)));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && !tmo_evt && !sw_rst_i) |=> run_en);

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && susp && !reload && !sw_rst_i) |=> $stable(units));

  p_flag_lead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag) |-> (units == {1'b0, lead}));

  p_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rst_o || ext_rst_o) |-> (cause == 3'b010));
endmodule

bind lf_watchdog lf_watchdog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_rst_i  (sw_rst_i),
  .int_rst_o (int_rst_o),
  .ext_rst_o (ext_rst_o),
  .run_en    (run_en),
  .ext_en    (ext_en),
  .no_ext    (no_ext),
  .no_int    (no_int),
  .tmo_evt   (tmo_evt),
  .susp      (susp),
  .reload    (reload),
  .load_tmo  (load_tmo),
  .units     (units),
  .lead      (lead),
  .irq_flag  (irq_flag),
  .cause     (cause)
);

// File: tb/lf_watchdog_bench.sv
module lf_watchdog_bench;
  import lfw_pkg::*;

  localparam int UNIT = 4;

  logic        clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0;
  logic        wait_m = 1'b0, dbg_m = 1'b0, lp_m = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        int_rst, ext_rst, irq;

  int cyc = 0, checks = 0, errors = 0;

  typedef struct {int kind; int at; string req;} ev_t;  // kind: 0 int, 1 ext, 2 irq
  ev_t expq[$];

  lf_watchdog #(.UNIT_CYCLES(UNIT)) u_lf_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst),
    .wait_mode_i(wait_m), .dbg_mode_i(dbg_m), .lp_mode_i(lp_m),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .int_rst_o(int_rst), .ext_rst_o(ext_rst), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h @%0d", req, act, exp, cyc);
    end
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected output rises and compares kind and cycle
  logic p_int = 1'b0, p_ext = 1'b0, p_irq = 1'b0;

  task automatic see(int kind, logic cur, logic prev);
    ev_t e;
    if (kind != 2 && cur && prev) begin
      checks++; errors++;
      $display("FAIL R2 pulse kind %0d act=2+cycles exp=1 cycle @%0d", kind, cyc);
    end
    if (cur && !prev) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL unexpected kind %0d act=rise@%0d exp=none", kind, cyc);
      end else begin
        e = expq.pop_front();
        if (e.kind != kind || e.at != cyc) begin
          errors++;
          $display("FAIL %s act=kind%0d@%0d exp=kind%0d@%0d", e.req, kind, cyc, e.kind, e.at);
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      see(0, int_rst, p_int);
      see(1, ext_rst, p_ext);
      see(2, irq, p_irq);
    end
    p_int = int_rst; p_ext = ext_rst; p_irq = irq;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outs", {13'b0, int_rst, ext_rst, irq}, 16'h0);
    rd(A_CTRL, 16'h0000, "R1 ctrl");
    rd(A_CAUSE, 16'h0010, "R1 cause");
    rd(A_IRQC, 16'h0000, "R1 irqc");
    rst_n = 1'b1;
    // R11 misc storage
    wr(A_MISC, 16'h0001); rd(A_MISC, 16'h0001, "R11 set");
    wr(A_MISC, 16'h0000); rd(A_MISC, 16'h0000, "R11 clr");

    // R2/R3/R8: T=3, ext enabled, lead 2
    wr(A_IRQC, 16'h8002);
    wr(A_CTRL, 16'h030C); e = cyc;
    push(2, e + 2*UNIT, "R8"); push(0, e + 4*UNIT, "R2"); push(1, e + 4*UNIT, "R3");
    wait_to(e + 4*UNIT + 4);
    rd(A_CAUSE, 16'h0002, "R9 cause");
    rd(A_CTRL, 16'h0000, "R9 ctrl");
    rd(A_IRQC, 16'h0000, "R9 irqc");

    // R6 sticky enable, R4 service, R8 clear
    wr(A_IRQC, 16'h8001);
    wr(A_CTRL, 16'h0204);
    wr(A_CTRL, 16'h0200);
    rd(A_CTRL, 16'h0204, "R6 sticky");
    wr(A_SVC, 16'h5555);
    wr(A_SVC, 16'hAAAA); s = cyc;
    push(2, s + 2*UNIT, "R8"); push(0, s + 3*UNIT, "R4");
    wait_to(s + 2*UNIT + 1);
    chk("R8 irq set", {15'b0, irq}, 16'h1);
    wr(A_IRQC, 16'hC001);
    chk("R8 irq clr", {15'b0, irq}, 16'h0);
    rd(A_IRQC, 16'h8001, "R8 flag clr");
    wait_to(s + 3*UNIT + 4);

    // R5 wrong value between keys
    wr(A_IRQC, 16'h0000);
    wr(A_CTRL, 16'h0104); e = cyc;
    wr(A_SVC, 16'h5555); wr(A_SVC, 16'h1234); wr(A_SVC, 16'hAAAA);
    push(0, e + 2*UNIT, "R5 bad key");
    wait_to(e + 2*UNIT + 4);
    // R5 other register write between keys
    wr(A_CTRL, 16'h0104); e = cyc;
    wr(A_SVC, 16'h5555); wr(A_MISC, 16'h0000); wr(A_SVC, 16'hAAAA);
    push(0, e + 2*UNIT, "R5 other write");
    wait_to(e + 2*UNIT + 4);

    // R3 masks
    wr(A_CTRL, 16'h001C); e = cyc;
    push(1, e + UNIT, "R3 int masked");
    wait_to(e + UNIT + 4);
    wr(A_CTRL, 16'h002C); e = cyc;
    push(0, e + UNIT, "R3 ext masked");
    wait_to(e + UNIT + 4);

    // R7 suspend: wait honoured, debug ignored
    wr(A_CTRL, 16'h0184); e = cyc;
    wait_m = 1'b1; dbg_m = 1'b1;
    repeat (5) @(negedge clk);
    wait_m = 1'b0; dbg_m = 1'b0;
    push(0, e + 2*UNIT + 5, "R7 wait");
    wait_to(e + 2*UNIT + 9);
    // R7 suspend: low-power honoured, wait ignored
    wr(A_CTRL, 16'h0105); e = cyc;
    lp_m = 1'b1; wait_m = 1'b1;
    repeat (3) @(negedge clk);
    lp_m = 1'b0; wait_m = 1'b0;
    push(0, e + 2*UNIT + 3, "R7 lp");
    wait_to(e + 2*UNIT + 7);

    // R10 software reset
    wr(A_CTRL, 16'h0A04);
    repeat (5) @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    rd(A_CAUSE, 16'h0001, "R10 cause");
    rd(A_CTRL, 16'h0000, "R10 ctrl");
    repeat (60) @(negedge clk);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL pending act=%0d exp=0 events", expq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule